// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a synchronous host and an external 32K-word by 8-bit asynchronous static RAM. The host presents one word request at a time through a request/ready handshake. The block turns each request into chip-select, output-enable and write-enable strobes. Every phase lasts a whole number of clock cycles, derived from the memory's minimum timings and the clock period. Read data comes back on `rdata` with a single-cycle `rvalid` pulse.

The memory data bus is split at the block boundary. `mem_dq_o` and `mem_dq_oe` feed a pad driver, and `mem_dq_i` returns the resolved pad value. The strobes and the driver enable are registered, and they are decoded from the next state.

The controller is a five-state machine:
- `ST_IDLE` has `ready` high and all strobes released. A request moves it to `ST_RD_STROBE` for a read. A write moves it to `ST_WR_STROBE`, or to `ST_WR_TURN` while the memory may still be driving the bus after a read.
- `ST_WR_TURN` waits for the float guard to expire, then enters `ST_WR_STROBE`.
- `ST_WR_STROBE` holds select and write enable low with the data driven, then enters `ST_WR_HOLD`.
- `ST_WR_HOLD` releases the strobes and keeps driving the data, then returns to `ST_IDLE`.
- `ST_RD_STROBE` holds select and output enable low, captures the bus on its last cycle and returns to `ST_IDLE`.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, `ready` is 1 and `rvalid` is 0.
- R2: The strobes take only three encodings (active low):
  - Idle: `mem_cs_n`=1 with `mem_oe_n`=1 and `mem_we_n`=1.
  - Read: `mem_cs_n`=0, `mem_oe_n`=0, `mem_we_n`=1, with `mem_dq_oe`=0.
  - Write: `mem_cs_n`=0, `mem_we_n`=0, `mem_oe_n`=1, with `mem_dq_oe`=1.
- R3: A request is taken only on a rising edge where `ready` and `req` are both 1; `we`=1 selects a write and `we`=0 a read. `ready` is 0 from the next cycle until the access ends. A request raised while `ready` is 0 has no effect.
- R4: A write holds `mem_we_n` low for N_WP cycles, with the data driven and unchanged throughout. The data stays driven for N_WH ≥ 1 further cycles after `mem_we_n` rises. N_WP is the largest of the write-pulse, data-setup and address-to-end-of-write counts.
- R5: `mem_addr` and `mem_dq_o` change only in cycles where `mem_cs_n` and `mem_we_n` are both high.
- R6: A read holds `mem_cs_n` and `mem_oe_n` low for N_RD cycles. N_RD is the largest of the address-access, output-enable-access and read-cycle counts. The bus is captured on the edge that ends the strobe, and `rdata` appears the next cycle with `rvalid` high for exactly one cycle.
- R7: `mem_dq_oe` is never raised within N_HZ cycles after `mem_oe_n` rises. A write accepted in the first idle cycle after a read spends exactly N_HZ cycles in `ST_WR_TURN`. A write that follows a write spends none.
- R8: `ready` stays low for N_RD cycles per read and for N_WC = max(write-cycle count, N_WP + N_WH) cycles per write, turnaround excluded.
- R9: Each phase count is the ceiling of the minimum time divided by `CLK_PERIOD_NS`, with a nonzero time giving at least one cycle. At the defaults (10 ns) this gives N_RD=7, N_WP=6, N_WH=1 and N_HZ=3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 15 | Word address |
| wdata | input | 8 | Write data |
| ready | output | 1 | Controller idle, request may be taken |
| rdata | output | 8 | Read data |
| rvalid | output | 1 | One-cycle read data valid |
| mem_addr | output | 15 | Memory address |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_o | output | 8 | Data to the pad driver |
| mem_dq_oe | output | 1 | Pad driver enable |
| mem_dq_i | input | 8 | Data from the pad |

## Verification
The assertions watch every cycle for these properties:
- only the legal strobe encodings appear;
- the address and the write data stay still while a strobe is active;
- write enable stays low for at least N_WP cycles, and the data outlives its rising edge;
- the driver comes on no earlier than N_HZ cycles after output enable is released;
- `rvalid` follows a read strobe of at least N_RD cycles.

Only the bench's scenarios can show the rest. These are that the words read back match what was written, that the exact phase lengths and the turnaround wait are used, and that a request raised while busy leaves the memory unchanged. A memory model in the bench shows these at the pins: it returns undefined data before the access time and flags any bus contention.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_STROBE,
        ST_WR_TURN,
        ST_WR_STROBE,
        ST_WR_HOLD
    } ctl_state_t;

    // Whole cycles covering t_ns; zero stays zero.
    function automatic int unsigned ns_to_cyc(input int unsigned t_ns,
                                              input int unsigned period_ns);
        if (t_ns == 0) return 0;
        return (t_ns + period_ns - 1) / period_ns;
    endfunction

    // Largest of three counts, never below one cycle.
    function automatic int unsigned max3_min1(input int unsigned a,
                                              input int unsigned b,
                                              input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        m = (m > c) ? m : c;
        return (m == 0) ? 1 : m;
    endfunction

endpackage

// File: rtl/asram_phase_cnt.sv
module asram_phase_cnt #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

    AST_LOAD_TAKES : assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val))) else $error("phase load lost"); // R9
endmodule

// File: rtl/asram_float_guard.sv
module asram_float_guard #(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned N_HZ  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic release_i,
    output logic busy
);
    localparam logic [CNT_W-1:0] HZ_LOAD = CNT_W'(N_HZ);

    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (release_i) begin
            left_q <= HZ_LOAD;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign busy = (left_q != '0);

    AST_GUARD_ARMS : assert property (@(posedge clk) disable iff (!rst_n)
        release_i |=> (busy || (N_HZ == 0))) else $error("float guard not armed"); // R7
endmodule

// File: rtl/asram_rd_capture.sv
module asram_rd_capture #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= take;
            if (take) rdata <= din;
        end
    end

    AST_RVALID_SINGLE : assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid) else $error("rvalid longer than one cycle"); // R6
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int unsigned ADDR_W        = 15,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned CNT_W         = 8,
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned T_RC_NS       = 70,
    parameter int unsigned T_AA_NS       = 70,
    parameter int unsigned T_OE_NS       = 35,
    parameter int unsigned T_HZ_NS       = 30,
    parameter int unsigned T_WC_NS       = 70,
    parameter int unsigned T_WP_NS       = 55,
    parameter int unsigned T_AW_NS       = 60,
    parameter int unsigned T_DW_NS       = 30,
    parameter int unsigned T_DH_NS       = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ready,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    // Phase lengths in cycles (R9).
    localparam int unsigned N_RD = max3_min1(ns_to_cyc(T_AA_NS, CLK_PERIOD_NS),
                                             ns_to_cyc(T_OE_NS, CLK_PERIOD_NS),
                                             ns_to_cyc(T_RC_NS, CLK_PERIOD_NS));
    localparam int unsigned N_WP = max3_min1(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                             ns_to_cyc(T_DW_NS, CLK_PERIOD_NS),
                                             ns_to_cyc(T_AW_NS, CLK_PERIOD_NS));
    localparam int unsigned N_DH = max3_min1(ns_to_cyc(T_DH_NS, CLK_PERIOD_NS), 0, 0);
    localparam int unsigned N_WC_RAW = ns_to_cyc(T_WC_NS, CLK_PERIOD_NS);
    localparam int unsigned N_WC = (N_WC_RAW > N_WP + N_DH) ? N_WC_RAW : N_WP + N_DH;
    localparam int unsigned N_WH = N_WC - N_WP;
    localparam int unsigned N_HZ = ns_to_cyc(T_HZ_NS, CLK_PERIOD_NS);

    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(N_RD - 1);
    localparam logic [CNT_W-1:0] WP_LOAD = CNT_W'(N_WP - 1);
    localparam logic [CNT_W-1:0] WH_LOAD = CNT_W'(N_WH - 1);

    ctl_state_t        state_q, state_nx;
    logic              phase_load, phase_done, hz_busy, rd_take;
    logic [CNT_W-1:0]  phase_val;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    asram_phase_cnt #(.CNT_W(CNT_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .load(phase_load),
        .load_val(phase_val), .done(phase_done)
    );

    asram_float_guard #(.CNT_W(CNT_W), .N_HZ(N_HZ)) u_guard (
        .clk(clk), .rst_n(rst_n), .release_i(rd_take), .busy(hz_busy)
    );

    asram_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .take(rd_take),
        .din(mem_dq_i), .rdata(rdata), .rvalid(rvalid)
    );

    assign ready    = (state_q == ST_IDLE);
    assign rd_take  = (state_q == ST_RD_STROBE) && phase_done;
    assign mem_addr = addr_q;
    assign mem_dq_o = data_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Next state and phase loading
    always_comb begin
        state_nx   = state_q;
        phase_load = 1'b0;
        phase_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    if (!we) begin
                        state_nx   = ST_RD_STROBE;
                        phase_load = 1'b1;
                        phase_val  = RD_LOAD;
                    end else if (hz_busy) begin
                        state_nx   = ST_WR_TURN;
                    end else begin
                        state_nx   = ST_WR_STROBE;
                        phase_load = 1'b1;
                        phase_val  = WP_LOAD;
                    end
                end
            end
            ST_WR_TURN: begin
                if (!hz_busy) begin
                    state_nx   = ST_WR_STROBE;
                    phase_load = 1'b1;
                    phase_val  = WP_LOAD;
                end
            end
            ST_WR_STROBE: begin
                if (phase_done) begin
                    state_nx   = ST_WR_HOLD;
                    phase_load = 1'b1;
                    phase_val  = WH_LOAD;
                end
            end
            ST_WR_HOLD: begin
                if (phase_done) state_nx = ST_IDLE;
            end
            ST_RD_STROBE: begin
                if (phase_done) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Request capture: only in the idle state, when all strobes are high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (ready && req) begin
            addr_q <= addr;
            if (we) data_q <= wdata;
        end
    end

    // Registered strobe outputs, decoded from the next state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_cs_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else begin
            mem_cs_n  <= !(state_nx inside {ST_RD_STROBE, ST_WR_STROBE});
            mem_oe_n  <= (state_nx != ST_RD_STROBE);
            mem_we_n  <= (state_nx != ST_WR_STROBE);
            mem_dq_oe <= (state_nx inside {ST_WR_STROBE, ST_WR_HOLD});
        end
    end

    // Run-length counters watched by the assertions below.
    logic [CNT_W-1:0] we_lo_run, oe_lo_run, oe_hi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_lo_run <= '0;
            oe_lo_run <= '0;
            oe_hi_run <= '1;
        end else begin
            we_lo_run <= mem_we_n ? '0 : ((we_lo_run == '1) ? we_lo_run : we_lo_run + 1'b1);
            oe_lo_run <= mem_oe_n ? '0 : ((oe_lo_run == '1) ? oe_lo_run : oe_lo_run + 1'b1);
            oe_hi_run <= !mem_oe_n ? '0 : ((oe_hi_run == '1) ? oe_hi_run : oe_hi_run + 1'b1);
        end
    end

    AST_IDLE_ALL_HIGH : assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs_n |-> (mem_oe_n && mem_we_n)) else $error("strobe low while deselected"); // R2
    AST_WRITE_OE_HIGH : assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs_n && mem_oe_n && mem_dq_oe)) else $error("bad write encoding"); // R2
    AST_READ_WE_HIGH : assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_dq_oe)) else $error("bad read encoding"); // R2
    AST_READY_IDLE : assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (mem_cs_n && !mem_dq_oe)) else $error("ready during access"); // R3
    AST_ACCEPT_BUSY : assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req) |=> !ready) else $error("ready after accept"); // R3
    AST_ADDR_HELD : assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n || !mem_we_n) |=> $stable(mem_addr)) else $error("address moved"); // R5
    AST_DATA_HELD : assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |=> (!mem_dq_oe || $stable(mem_dq_o))) else $error("write data moved"); // R4
    AST_WP_MIN : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_lo_run >= CNT_W'(N_WP))) else $error("write pulse short"); // R4
    AST_DH_AFTER_WE : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_dq_oe) else $error("no data hold"); // R4
    AST_FLOAT_GAP : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (oe_hi_run >= CNT_W'(N_HZ))) else $error("driver too early"); // R7
    AST_RD_ACCESS : assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> (oe_lo_run >= CNT_W'(N_RD))) else $error("read strobe short"); // R6
endmodule

// File: tb/asram_ctrl_tb_top.sv
module asram_ctrl_tb_top;
    localparam int PER  = 10;
    localparam int T_AA = 70;
    localparam int T_HZ = 30;
    localparam int T_WP = 55;
    localparam int T_DW = 30;
    // Expected phase counts, from the requirements at a 10 ns clock (R9).
    localparam int E_RD = (70 + PER - 1) / PER;   // 7
    localparam int E_WP = (60 + PER - 1) / PER;   // 6
    localparam int E_WH = 1;
    localparam int E_HZ = (T_HZ + PER - 1) / PER; // 3

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0;
    logic [14:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        ready, rvalid, mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  rdata, mem_dq_o, dq_drv;
    logic [14:0] mem_addr;

    always #5 clk = ~clk;

    asram_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .ready(ready), .rdata(rdata), .rvalid(rvalid), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(dq_drv)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    logic [7:0] ref_mem   [0:32767];
    logic [7:0] model_mem [0:32767];

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic print_summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // ---------------- behavioural memory model ----------------
    int rd_k = 0, rel_k = 100, wr_k = 0, dw_k = 0;
    bit was_rd = 0, was_wr = 0, prev_cs_lo = 0;
    logic [7:0]  wr_dat = '0;
    logic [14:0] prev_addr = '0;

    always @(negedge clk) begin
        bit rd_mode, wr_mode, floating;
        if (!rst_n) begin
            dq_drv = 'x; rd_k = 0; rel_k = 100; wr_k = 0; dw_k = 0;
            was_rd = 0; was_wr = 0; prev_cs_lo = 0;
        end else begin
            rd_mode = !mem_cs_n && !mem_oe_n && mem_we_n;
            wr_mode = !mem_cs_n && !mem_we_n;
            if (rd_mode) begin
                rd_k++; rel_k = 0;
                dq_drv = (rd_k * PER >= T_AA) ? model_mem[mem_addr] : 'x;
            end else begin
                if (was_rd) rel_k = 0;
                else if (rel_k < 100) rel_k++;
                rd_k = 0; dq_drv = 'x;
            end
            floating = rd_mode || (rel_k * PER + PER / 2 < T_HZ);
            if (mem_dq_oe && floating)
                chk("R7 bus contention with memory", 1, 0);
            if (!mem_cs_n && prev_cs_lo && mem_addr !== prev_addr)
                chk("R5 address moved under select", {17'd0, mem_addr}, {17'd0, prev_addr});
            if (wr_mode) begin
                if (!mem_oe_n) chk("R2 output enable low in write", 0, 1);
                if (!was_wr || !mem_dq_oe || mem_dq_o !== wr_dat) dw_k = mem_dq_oe ? 1 : 0;
                else dw_k++;
                wr_dat = mem_dq_o; wr_k++;
            end else if (was_wr) begin
                chk("R4 write pulse width ok", (wr_k * PER >= T_WP), 1);
                chk("R4 data setup ok", (dw_k * PER >= T_DW), 1);
                chk("R4 data held after strobe", (mem_dq_oe && mem_dq_o === wr_dat), 1);
                model_mem[prev_addr] = wr_dat;
                wr_k = 0; dw_k = 0;
            end
            was_rd = rd_mode; was_wr = wr_mode;
            prev_cs_lo = !mem_cs_n; prev_addr = mem_addr;
        end
    end

    // ---------------- host helpers ----------------
    task automatic host_write(input logic [14:0] a, input logic [7:0] d,
                              output int busy, output int wp, output int turn, output int hold);
        while (!ready) @(negedge clk);
        req = 1; we = 1; addr = a; wdata = d;
        ref_mem[a] = d;
        @(negedge clk);
        req = 0;
        busy = 0; wp = 0; turn = 0; hold = 0;
        chk("R3 ready low after write accept", ready, 0);
        while (!ready) begin
            busy++;
            if (!mem_we_n) wp++;
            else if (mem_dq_oe) hold++;
            else turn++;
            @(negedge clk);
        end
    endtask

    task automatic host_read(input logic [14:0] a, output logic [7:0] d, output bit v,
                             output int busy, output int oe_lo);
        while (!ready) @(negedge clk);
        req = 1; we = 0; addr = a;
        @(negedge clk);
        req = 0;
        busy = 0; oe_lo = 0;
        chk("R3 ready low after read accept", ready, 0);
        while (!ready) begin
            busy++;
            if (!mem_oe_n) oe_lo++;
            @(negedge clk);
        end
        d = rdata; v = rvalid;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        chk("R1 cs_n after reset", mem_cs_n, 1);
        chk("R1 oe_n after reset", mem_oe_n, 1);
        chk("R1 we_n after reset", mem_we_n, 1);
        chk("R1 dq_oe after reset", mem_dq_oe, 0);
        chk("R1 ready after reset", ready, 1);
        chk("R1 rvalid after reset", rvalid, 0);
    endtask

    task automatic t_write_timing;
        int b, w, t, h;
        host_write(15'h0000, 8'hA5, b, w, t, h);
        chk("R9 write strobe cycles", w, E_WP);
        chk("R4 hold cycles after strobe", h, E_WH);
        chk("R8 write busy cycles", b, E_WP + E_WH);
        host_write(15'h0001, 8'h3C, b, w, t, h);
        chk("R7 no turnaround after write", t, 0);
    endtask

    task automatic t_read_after_write;
        logic [7:0] d; bit v; int b, o;
        host_read(15'h0000, d, v, b, o);
        chk("R6 read data after write", d, 8'hA5);
        chk("R6 rvalid with data", v, 1);
        chk("R9 read strobe cycles", o, E_RD);
        chk("R8 read busy cycles", b, E_RD);
        @(negedge clk);
        chk("R6 rvalid single cycle", rvalid, 0);
    endtask

    task automatic t_write_after_read;
        logic [7:0] d; bit v; int b, o, w, t, h;
        host_read(15'h0001, d, v, b, o);
        chk("R6 read back 3C", d, 8'h3C);
        host_write(15'h0002, 8'h96, b, w, t, h);
        chk("R7 turnaround cycles", t, E_HZ);
        chk("R8 write busy with turnaround", b, E_HZ + E_WP + E_WH);
        host_read(15'h0002, d, v, b, o);
        chk("R6 read after turnaround write", d, 8'h96);
    endtask

    task automatic t_patterns;
        logic [14:0] al [4] = '{15'h7FFF, 15'h0003, 15'h4000, 15'h2AAA};
        logic [7:0]  dl [4] = '{8'hFF, 8'h00, 8'h5A, 8'hC3};
        logic [7:0] d; bit v; int b, o, w, t, h;
        foreach (al[i]) host_write(al[i], dl[i], b, w, t, h);
        for (int i = 3; i >= 0; i--) begin
            host_read(al[i], d, v, b, o);
            chk("R6 pattern read back", d, ref_mem[al[i]]);
        end
        for (int i = 0; i < 8; i++) begin
            logic [14:0] a = 15'(i * 4099 + 17);
            host_write(a, 8'(i * 37 + 1), b, w, t, h);
            host_read(a, d, v, b, o);
            chk("R6 interleaved read back", d, ref_mem[a]);
            chk("R2 write strobe length interleaved", w, E_WP);
        end
    endtask

    task automatic t_req_ignored;
        logic [7:0] d; bit v; int b, o, w, t, h, we_lo;
        host_write(15'h1234, 8'h11, b, w, t, h);
        host_write(15'h0777, 8'h22, b, w, t, h);
        req = 1; we = 0; addr = 15'h1234;
        @(negedge clk);
        we_lo = 0;
        // Stray write request while busy (R3)
        req = 1; we = 1; addr = 15'h0777; wdata = 8'hEE;
        @(negedge clk);
        req = 0; we = 0;
        while (!ready) begin
            if (!mem_we_n) we_lo++;
            @(negedge clk);
        end
        chk("R3 read done despite stray request", rdata, 8'h11);
        chk("R3 no write strobe from stray request", we_lo, 0);
        host_read(15'h0777, d, v, b, o);
        chk("R3 memory unchanged by stray request", d, 8'h22);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_write_timing();
        t_read_after_write();
        t_write_after_read();
        t_patterns();
        t_req_ignored();
        repeat (5) @(negedge clk);
        finished = 1;
        print_summary();
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL R3 watchdog: actual hung expected done");
            print_summary();
            $finish;
        end
    end
endmodule